// File: doc/BRIEF.md
# Infrared Frame Byte Unescaper

This block sits on the receive side of an infrared link, after the deserializer and flag detector. It takes the raw bytes of a frame's address, control, information and checksum fields, one per cycle when `byte_valid_i` is high. It removes transparency escape bytes and restores the byte that follows each escape to its original value. Each restored byte goes out on one data bus together with a receive FIFO write strobe and a checksum strobe, both raised in the same cycle.

The flag detector marks the frame edges with `frame_start_i` and `frame_end_i`. An escape byte directly followed by an unescaped end code is the abort pattern. The block reports it as a one-cycle abort pulse and forwards no data for either byte. A frame that ends while an escape is still waiting for its partner byte raises a one-cycle framing-error pulse. All outputs are registered and appear one cycle after the input that causes them.

Top module: `ir_unescape`

## Requirements
- R1: While `rst_ni` is low, every output is low, and no escape is pending when reset is released.
- R2: A valid byte other than 0x7D that arrives with no escape pending is output unchanged on `fifo_data_o`, with `fifo_we_o` high, in the next cycle.
- R3: A valid 0x7D that arrives with no escape pending produces no write and no checksum strobe, and makes an escape pending.
- R4: A valid byte other than 0xC1 that arrives while an escape is pending is output XORed with 0x20 (bit 5 inverted) in the next cycle, and the pending escape is cleared. A second 0x7D therefore comes out as 0x5D.
- R5: A valid 0xC1 that arrives while an escape is pending raises `abort_o` for exactly one cycle in the next cycle, writes no data and clears the pending escape.
- R6: `frame_start_i` raises `frame_start_o` in the next cycle and clears any pending escape. A byte presented in the same cycle is decoded as the first byte of the new frame.
- R7: `frame_end_i` clears the pending escape. If an escape is pending once any byte in the same cycle has been decoded, `frame_err_o` is high for one cycle in the next cycle.
- R8: `crc_en_o` is high in exactly the cycles in which `fifo_we_o` is high, and both qualify the same `fifo_data_o`.
- R9: A cycle with `byte_valid_i` low produces no write, and the pending state is held across it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Opening flag seen (pulse) |
| frame_end_i | input | 1 | Closing flag seen (pulse) |
| byte_valid_i | input | 1 | `byte_i` carries a raw field byte |
| byte_i | input | 8 | Raw received byte |
| fifo_we_o | output | 1 | Receive FIFO write strobe |
| crc_en_o | output | 1 | Checksum engine byte strobe |
| fifo_data_o | output | 8 | Restored byte |
| frame_start_o | output | 1 | Frame start event |
| abort_o | output | 1 | Abort pattern event |
| frame_err_o | output | 1 | Frame ended with an escape pending |

## Verification
The bench goes after the escape-pending state at its edges. It sends an escape followed by the end code, which a faulty design forwards as 0xE1 instead of aborting. It sends a doubled escape, which must come out as 0x5D; a design that re-arms the escape would swallow the byte. It puts a frame start in the same cycle as a byte after a dangling escape, where a design that does not clear the state first would flip that byte or report an abort. It places idle gaps between an escape and its partner, and ends frames with an escape pending. Encoded payloads full of the three special codes must come back byte for byte, so a wrong mask, a wrong order or a lost byte shows up in the restored stream.

// File: rtl/ir_unescape_pkg.sv
package ir_unescape_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] ESC_CODE_DEF   = 8'h7D;
  localparam logic [BYTE_W-1:0] ABORT_CODE_DEF = 8'hC1;
  localparam logic [BYTE_W-1:0] FLIP_MASK_DEF  = 8'h20;

  typedef enum logic {
    ST_PLAIN = 1'b0,
    ST_ESC   = 1'b1
  } esc_state_e;

  typedef struct packed {
    logic              wr;
    logic              abort;
    logic              err;
    logic              start;
    logic [BYTE_W-1:0] data;
  } out_evt_t;
endpackage

// File: rtl/ir_unescape_classify.sv
module ir_unescape_classify
  import ir_unescape_pkg::*;
#(
  parameter logic [BYTE_W-1:0] ESC_CODE   = ESC_CODE_DEF,
  parameter logic [BYTE_W-1:0] ABORT_CODE = ABORT_CODE_DEF,
  parameter logic [BYTE_W-1:0] FLIP_MASK  = FLIP_MASK_DEF
) (
  input  logic [BYTE_W-1:0] byte_i,
  output logic              is_esc_o,
  output logic              is_abort_o,
  output logic [BYTE_W-1:0] flipped_o
);
  assign is_esc_o   = (byte_i == ESC_CODE);
  assign is_abort_o = (byte_i == ABORT_CODE);
  assign flipped_o  = byte_i ^ FLIP_MASK;
endmodule

// File: rtl/ir_unescape_ctrl.sv
module ir_unescape_ctrl
  import ir_unescape_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic start_i,
  input  logic end_i,
  input  logic is_esc_i,
  input  logic is_abort_i,
  output logic pend_o,
  output logic fwd_o,
  output logic flip_o,
  output logic abort_o,
  output logic err_o
);
  esc_state_e state_q, state_d;
  logic pend, esc_next;

  // a frame start discards any escape left over from the previous frame
  assign pend = (state_q == ST_ESC) && !start_i;

  always_comb begin
    fwd_o    = 1'b0;
    abort_o  = 1'b0;
    esc_next = pend;
    if (valid_i) begin
      if (pend) begin
        abort_o  = is_abort_i;
        fwd_o    = !is_abort_i;
        esc_next = 1'b0;
      end else if (is_esc_i) begin
        esc_next = 1'b1;
      end else begin
        fwd_o = 1'b1;
      end
    end
  end

  assign flip_o = pend;
  assign pend_o = pend;
  assign err_o  = end_i && esc_next;

  always_comb begin
    state_d = esc_next ? ST_ESC : ST_PLAIN;
    if (end_i) state_d = ST_PLAIN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_PLAIN;
    else         state_q <= state_d;
  end

  // R3
  a_r3_esc_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !pend && is_esc_i && !end_i |=> state_q == ST_ESC);
  // R5
  a_r5_abort_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> state_q == ST_PLAIN);
  // R9
  a_r9_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i && !start_i && !end_i |=> $stable(state_q));
  // R7
  a_r7_end_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_i |=> state_q == ST_PLAIN);
endmodule

// File: rtl/ir_unescape_out.sv
module ir_unescape_out
  import ir_unescape_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  out_evt_t evt_i,
  output logic     fifo_we_o,
  output logic     crc_en_o,
  output logic [BYTE_W-1:0] data_o,
  output logic     start_o,
  output logic     abort_o,
  output logic     err_o
);
  out_evt_t evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else         evt_q <= evt_i;
  end

  assign fifo_we_o = evt_q.wr;
  assign crc_en_o  = evt_q.wr;
  assign data_o    = evt_q.data;
  assign start_o   = evt_q.start;
  assign abort_o   = evt_q.abort;
  assign err_o     = evt_q.err;
endmodule

// File: rtl/ir_unescape.sv
module ir_unescape
  import ir_unescape_pkg::*;
#(
  parameter logic [BYTE_W-1:0] ESC_CODE   = ESC_CODE_DEF,
  parameter logic [BYTE_W-1:0] ABORT_CODE = ABORT_CODE_DEF,
  parameter logic [BYTE_W-1:0] FLIP_MASK  = FLIP_MASK_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              frame_end_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              fifo_we_o,
  output logic              crc_en_o,
  output logic [BYTE_W-1:0] fifo_data_o,
  output logic              frame_start_o,
  output logic              abort_o,
  output logic              frame_err_o
);
  logic is_esc, is_abort, pend, fwd, flip, abort_evt, err_evt;
  logic [BYTE_W-1:0] flipped;
  out_evt_t evt;

  ir_unescape_classify #(
    .ESC_CODE  (ESC_CODE),
    .ABORT_CODE(ABORT_CODE),
    .FLIP_MASK (FLIP_MASK)
  ) u_classify (
    .byte_i    (byte_i),
    .is_esc_o  (is_esc),
    .is_abort_o(is_abort),
    .flipped_o (flipped)
  );

  ir_unescape_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (byte_valid_i),
    .start_i   (frame_start_i),
    .end_i     (frame_end_i),
    .is_esc_i  (is_esc),
    .is_abort_i(is_abort),
    .pend_o    (pend),
    .fwd_o     (fwd),
    .flip_o    (flip),
    .abort_o   (abort_evt),
    .err_o     (err_evt)
  );

  always_comb begin
    evt       = '0;
    evt.wr    = fwd;
    evt.abort = abort_evt;
    evt.err   = err_evt;
    evt.start = frame_start_i;
    evt.data  = flip ? flipped : byte_i;
  end

  ir_unescape_out u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt),
    .fifo_we_o(fifo_we_o),
    .crc_en_o (crc_en_o),
    .data_o   (fifo_data_o),
    .start_o  (frame_start_o),
    .abort_o  (abort_o),
    .err_o    (frame_err_o)
  );

  // R2
  a_r2_plain_forward: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_i && !pend && byte_i != ESC_CODE |=>
      fifo_we_o && fifo_data_o == $past(byte_i));
  // R4
  a_r4_flip_forward: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_i && pend && byte_i != ABORT_CODE |=>
      fifo_we_o && fifo_data_o == ($past(byte_i) ^ FLIP_MASK));
  // R5
  a_r5_abort_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({abort_o, fifo_we_o}));
  // R5
  a_r5_abort_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_i && pend && byte_i == ABORT_CODE |=> abort_o && !fifo_we_o);
  // R6
  a_r6_start_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> frame_start_o);
  // R7
  a_r7_err_needs_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> $past(frame_end_i));
  // R8
  a_r8_write_needs_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_we_o || crc_en_o) |-> $past(byte_valid_i));
  // R1
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> !fifo_we_o && !crc_en_o && !abort_o && !frame_err_o && !frame_start_o);
endmodule

// File: tb/ir_unescape_tb_top.sv
module ir_unescape_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, end_i = 1'b0, valid_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic       fifo_we, crc_en, start_o, abort_o, err_o;
  logic [7:0] data_o;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit done = 0;

  // reference model state
  bit         m_pend = 0;
  bit         e_we = 0, e_start = 0, e_abort = 0, e_err = 0;
  logic [7:0] e_data = '0;
  string      e_tag = "R2";

  logic [7:0] got_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ir_unescape dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .frame_start_i(start_i),
    .frame_end_i  (end_i),
    .byte_valid_i (valid_i),
    .byte_i       (byte_i),
    .fifo_we_o    (fifo_we),
    .crc_en_o     (crc_en),
    .fifo_data_o  (data_o),
    .frame_start_o(start_o),
    .abort_o      (abort_o),
    .frame_err_o  (err_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0; e_we = 0; e_start = 0; e_abort = 0; e_err = 0; e_data = '0;
    end else begin
      bit p;
      p = m_pend && !start_i;
      e_we = 0; e_abort = 0; e_tag = "R9";
      if (valid_i) begin
        if (p) begin
          p = 0;
          if (byte_i == 8'hC1) begin e_abort = 1; e_tag = "R5"; end
          else begin e_we = 1; e_data = byte_i ^ 8'h20; e_tag = "R4"; end
        end else if (byte_i == 8'h7D) begin
          p = 1; e_tag = "R3";
        end else begin
          e_we = 1; e_data = byte_i; e_tag = "R2";
        end
      end
      e_err = end_i && p;
      if (end_i) p = 0;
      m_pend = p;
      e_start = start_i;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst_n) begin
      n_cmp++;
      chk("R1", {3'b0, fifo_we, crc_en, start_o, abort_o, err_o}, 8'h00);
    end else begin
      n_cmp++;
      chk(e_tag, {7'b0, fifo_we}, {7'b0, e_we});
      chk("R8", {7'b0, crc_en}, {7'b0, e_we});
      if (e_we) chk(e_tag, data_o, e_data);
      chk("R6", {7'b0, start_o}, {7'b0, e_start});
      chk("R5", {7'b0, abort_o}, {7'b0, e_abort});
      chk("R7", {7'b0, err_o}, {7'b0, e_err});
      if (fifo_we) got_q.push_back(data_o);
    end
  end

  task automatic drive(input bit v, input logic [7:0] b, input bit s, input bit e);
    @(negedge clk);
    valid_i = v; byte_i = b; start_i = s; end_i = e;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 8'h00, 0, 0);
  endtask

  // encode payload with transparency, send it, compare the restored stream (R2, R4)
  task automatic roundtrip(input logic [7:0] pl[$], input string tag);
    drive(0, 8'h00, 1, 0);
    got_q.delete();
    foreach (pl[i]) begin
      if (pl[i] == 8'hC0 || pl[i] == 8'hC1 || pl[i] == 8'h7D) begin
        drive(1, 8'h7D, 0, 0);
        drive(1, pl[i] ^ 8'h20, 0, 0);
      end else drive(1, pl[i], 0, 0);
    end
    drive(0, 8'h00, 0, 1);
    idle(2);
    n_cmp++;
    if (got_q.size() != pl.size()) begin
      n_bad++;
      $display("FAIL %s: actual %0d bytes expected %0d bytes", tag, got_q.size(), pl.size());
    end else foreach (pl[i]) chk(tag, got_q[i], pl[i]);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    logic [7:0] pl[$];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    // R2 plain frame
    pl = '{8'h01, 8'h02, 8'h03, 8'hFF, 8'h00};
    roundtrip(pl, "R2");
    // R4 all special codes, back to back
    pl = '{8'hC0, 8'h7D, 8'hC1, 8'h11, 8'h7D, 8'h7D, 8'h20, 8'h5D};
    roundtrip(pl, "R4");
    // R5 abort pattern mid-frame
    drive(0, 8'h00, 1, 0);
    drive(1, 8'h33, 0, 0);
    drive(1, 8'h7D, 0, 0);
    drive(1, 8'hC1, 0, 0);
    drive(1, 8'h44, 0, 0);
    drive(0, 8'h00, 0, 1);
    idle(2);
    // R4 raw doubled escape gives 0x5D
    drive(1, 8'h7D, 0, 0);
    drive(1, 8'h7D, 0, 0);
    idle(2);
    // R7 end with escape pending, also same-cycle escape with end
    drive(1, 8'h7D, 0, 0);
    drive(0, 8'h00, 0, 1);
    drive(1, 8'h7D, 0, 1);
    drive(1, 8'h41, 0, 0);
    idle(2);
    // R6 start clears dangling escape; same-cycle byte decoded plain
    drive(1, 8'h7D, 0, 0);
    drive(1, 8'hC1, 1, 0);
    drive(1, 8'h7D, 0, 0);
    drive(1, 8'h52, 1, 0);
    idle(2);
    // R9 idle gaps between escape and its partner
    drive(1, 8'h7D, 0, 0);
    idle(3);
    drive(1, 8'h45, 0, 0);
    drive(1, 8'h7D, 0, 0);
    idle(2);
    drive(1, 8'hC1, 0, 0);
    idle(2);
    // mixed random traffic biased toward the special codes
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [7:0] b;
      r = $urandom_range(0, 9);
      b = (r < 3) ? 8'h7D : (r < 5) ? 8'hC1 : (r < 6) ? 8'hC0 : 8'($urandom);
      drive($urandom_range(0, 3) != 0, b, $urandom_range(0, 40) == 0,
            $urandom_range(0, 30) == 0);
    end
    idle(3);
    done = 1;
    summary();
  end

  initial begin
    wait (cycles >= WATCHDOG);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      summary();
    end
  end
endmodule